// File: doc/BRIEF.md
# CRC-16 / CRC-32 Checksum Engine

This block computes a cyclic redundancy check over a stream of bytes delivered through a small single-cycle register port. Software selects a 16-bit or 32-bit CRC, may preset the checksum register (for example to all ones), enables the engine, writes data bytes one per cycle, and then ends the run with a done command or by disabling the engine. Each accepted byte is folded into the checksum in the same clock in which it is written.

Both CRCs are processed least-significant bit first as right-shifting registers. The 16-bit generator 0x1021 is applied in its reflected form 0x8408. The 32-bit generator is the reflected constant 0xEDB88320. The checksum reads back raw in 16-bit mode and during a run. In 32-bit mode, once the run has ended, it reads back bit-reversed and inverted.

Register map on `addr`: 0 = control, 1 = data, 2 = checksum, 3 = status. Reads are combinational from `addr`. Writes happen on a clock edge while `wr_en` is high.

Top module: `crc_engine`

## Requirements
- R1: After reset the checksum register holds 0, the engine is disabled, busy is clear and the mode is CRC-16. Control (addr 0) reads bit 0 = enable and bit 1 = mode, and status (addr 3) reads bit 0 = busy. All other read bits are 0.
- R2: While the engine is disabled, a write to the checksum register (addr 2) loads all 32 bits of `wr_data`.
- R3: While the engine is enabled, a write to the checksum register is ignored.
- R4: In CRC-16 mode (control bit 1 = 0), an enabled write to the data register (addr 1) folds `wr_data[7:0]` into the low 16 bits of the checksum. Bits go in LSB first, with a right shift and the constant 0x8408, and the upper 16 stored bits are cleared.
- R5: In CRC-32 mode (control bit 1 = 1), an enabled data write folds `wr_data[7:0]` into all 32 bits. Bits go in LSB first, with a right shift and the constant 0xEDB88320.
- R6: A data write while the engine is disabled leaves the checksum unchanged.
- R7: Busy is set by a data write while enabled. It is cleared by a control write whose bit 2 (done strobe) is 1 or whose bit 0 is 0. Bit 2 is not stored.
- R8: A control write loads the enable bit 0 at any time. Bit 1 (mode) is taken only if the engine was disabled before that write; otherwise the mode is kept.
- R9: In CRC-32 mode with busy clear, a checksum read returns the stored value with bit i moved to bit 31-i, and then inverted.
- R10: In CRC-16 mode, or whenever busy is set, a checksum read returns the stored value untransformed. In CRC-16 mode bits 31:16 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |

## Verification
The checker watches these rules on every cycle: the checksum holds when a write is locked out or comes while the engine is idle, the mode holds while enabled, busy rises only from an accepted byte and is never set while disabled, and the upper half reads zero in 16-bit mode. Only the bench's scenarios can show that the CRC values are arithmetically correct, including the standard nine-character check string in 32-bit mode. The same holds for the reversed and inverted read-back after a run, and for the interplay of preset, mode switching and done commands across random sequences.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int SUM_W   = 32;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 2;

    localparam logic [SUM_W-1:0]  POLY32_REFL = 32'hEDB8_8320;
    localparam logic [HALF_W-1:0] POLY16_REFL = 16'h8408;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SUM  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_DONE_BIT = 2;

    typedef enum logic {
        MODE_CRC16 = 1'b0,
        MODE_CRC32 = 1'b1
    } crc_mode_e;

    typedef struct packed {
        logic      enable;
        crc_mode_e mode;
        logic      busy;
    } ctrl_state_t;

    typedef struct packed {
        logic       fire;
        logic [BYTE_W-1:0] data;
    } byte_req_t;

    typedef struct packed {
        logic             load;
        logic [SUM_W-1:0] value;
    } preset_req_t;

    function automatic logic [SUM_W-1:0] mirror32(input logic [SUM_W-1:0] v);
        logic [SUM_W-1:0] r;
        for (int i = 0; i < SUM_W; i++) begin
            r[i] = v[SUM_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic [2:0]        ctrl_bits,
    output ctrl_state_t       state_q,
    output logic              accept_byte
);

    ctrl_state_t state_d;

    assign accept_byte = data_wr && state_q.enable;

    always_comb begin
        state_d = state_q;
        if (accept_byte) begin
            state_d.busy = 1'b1;
        end
        if (ctrl_wr) begin
            if (!state_q.enable) begin
                state_d.mode = crc_mode_e'(ctrl_bits[CTRL_MODE_BIT]);
            end
            state_d.enable = ctrl_bits[CTRL_EN_BIT];
            if (ctrl_bits[CTRL_DONE_BIT] || !ctrl_bits[CTRL_EN_BIT]) begin
                state_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{enable: 1'b0, mode: MODE_CRC16, busy: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/crc_core.sv
module crc_core
    import crc_pkg::*;
#(
    parameter int W     = SUM_W,
    parameter int HW    = HALF_W,
    parameter int BW    = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  crc_mode_e     mode,
    input  byte_req_t     byte_req,
    input  preset_req_t   preset,
    output logic [W-1:0]  sum_q
);

    localparam logic [W-1:0]  P_WIDE   = W'(POLY32_REFL);
    localparam logic [HW-1:0] P_NARROW = HW'(POLY16_REFL);

    logic [W-1:0]  wide_chain   [BW+1];
    logic [HW-1:0] narrow_chain [BW+1];
    logic [W-1:0]  sum_d;

    assign wide_chain[0]   = sum_q;
    assign narrow_chain[0] = sum_q[HW-1:0];

    for (genvar b = 0; b < BW; b++) begin : g_bit
        logic wide_fb;
        logic narrow_fb;
        assign wide_fb   = wide_chain[b][0] ^ byte_req.data[b];
        assign narrow_fb = narrow_chain[b][0] ^ byte_req.data[b];
        assign wide_chain[b+1]   = (wide_chain[b] >> 1) ^ (wide_fb ? P_WIDE : '0);
        assign narrow_chain[b+1] = (narrow_chain[b] >> 1) ^ (narrow_fb ? P_NARROW : '0);
    end

    always_comb begin
        sum_d = sum_q;
        if (preset.load) begin
            sum_d = preset.value;
        end else if (byte_req.fire) begin
            if (mode == MODE_CRC32) begin
                sum_d = wide_chain[BW];
            end else begin
                sum_d = {{(W-HW){1'b0}}, narrow_chain[BW]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

endmodule

// File: rtl/crc_readback.sv
module crc_readback
    import crc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_state_t       state,
    input  logic [SUM_W-1:0]  sum,
    output logic [SUM_W-1:0]  rd_data
);

    logic [SUM_W-1:0] sum_view;

    always_comb begin
        if (state.mode == MODE_CRC16) begin
            sum_view = {{(SUM_W-HALF_W){1'b0}}, sum[HALF_W-1:0]};
        end else if (state.busy) begin
            sum_view = sum;
        end else begin
            sum_view = ~mirror32(sum);
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rd_data[CTRL_EN_BIT]   = state.enable;
                rd_data[CTRL_MODE_BIT] = state.mode;
            end
            ADDR_SUM:  rd_data = sum_view;
            ADDR_STAT: rd_data[0] = state.busy;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data
);

    ctrl_state_t      state_q;
    logic             accept_byte;
    logic             en_q;
    logic             busy_q;
    logic             mode_q;
    logic [SUM_W-1:0] sum_q;
    byte_req_t        byte_req;
    preset_req_t      preset;

    crc_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ctrl_wr     (wr_en && addr == ADDR_CTRL),
        .data_wr     (wr_en && addr == ADDR_DATA),
        .ctrl_bits   (wr_data[2:0]),
        .state_q     (state_q),
        .accept_byte (accept_byte)
    );

    assign byte_req.fire = accept_byte;
    assign byte_req.data = wr_data[BYTE_W-1:0];
    assign preset.load   = wr_en && addr == ADDR_SUM && !state_q.enable;
    assign preset.value  = wr_data;

    crc_core u_core (
        .clk      (clk),
        .rst      (rst),
        .mode     (state_q.mode),
        .byte_req (byte_req),
        .preset   (preset),
        .sum_q    (sum_q)
    );

    crc_readback u_rd (
        .addr    (addr),
        .state   (state_q),
        .sum     (sum_q),
        .rd_data (rd_data)
    );

    assign en_q   = state_q.enable;
    assign busy_q = state_q.busy;
    assign mode_q = state_q.mode;

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
    import crc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [31:0] rd_data,
    input logic        en_q,
    input logic        busy_q,
    input logic        mode_q,
    input logic [31:0] sum_q
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (sum_q == '0 && !busy_q && !en_q && !mode_q));

    assert_locked_preset_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_SUM && en_q) |=> $stable(sum_q));

    assert_idle_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_DATA && !en_q) |=> $stable(sum_q));

    assert_busy_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(wr_en && addr == ADDR_DATA && en_q));

    assert_busy_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !busy_q);

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        en_q |=> $stable(mode_q));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && addr == ADDR_SUM) |-> rd_data[31:16] == 16'h0);

endmodule

bind crc_engine crc_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .rd_data (rd_data),
    .en_q    (en_q),
    .busy_q  (busy_q),
    .mode_q  (mode_q),
    .sum_q   (sum_q)
);

// File: tb/tb_crc_engine.sv
module tb_crc_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_sum;
    logic        m_en, m_mode, m_busy;

    always #2 clk = ~clk;

    crc_engine dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [31:0] ref_crc32(input logic [31:0] s, input logic [7:0] d);
        logic [31:0] c = s;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320;
            else             c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_crc16(input logic [15:0] s, input logic [7:0] d);
        logic [15:0] c = s;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 16'h8408;
            else             c = c >> 1;
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_rev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {30'h0, m_mode, m_en};
            2'd2: begin
                if (!m_mode)     return {16'h0, m_sum[15:0]};
                else if (m_busy) return m_sum;
                else             return ~ref_rev(m_sum);
            end
            2'd3: return {31'h0, m_busy};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string req);
        addr = a;
        wr_en = 1'b0;
        #1;
        check(req, rd_data, exp_read(a));
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        case (a)
            2'd0: begin
                if (!m_en) m_mode = d[1];
                if (d[2] || !d[0]) m_busy = 1'b0;
                m_en = d[0];
            end
            2'd1: if (m_en) begin
                if (m_mode) m_sum = ref_crc32(m_sum, d[7:0]);
                else        m_sum = {16'h0, ref_crc16(m_sum[15:0], d[7:0])};
                m_busy = 1'b1;
            end
            2'd2: if (!m_en) m_sum = d;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        string msg = "123456789";
        void'($urandom(32'd20240611));
        m_sum = '0; m_en = 1'b0; m_mode = 1'b0; m_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd2, "R1 sum");
        rd(2'd0, "R1 ctrl");
        rd(2'd3, "R1 busy");
        check("R1 raw sum", rd_data, 32'h0);

        // R2 preset, then R5 check string in CRC-32
        wr(2'd0, 32'h2);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h3);
        for (int i = 0; i < 9; i++) wr(2'd1, {24'h0, msg[i]});
        addr = 2'd2; #1;
        check("R5 R10 busy raw", rd_data, 32'h340B_C6D9);
        addr = 2'd3; #1;
        check("R7 busy set", rd_data, 32'h1);
        // R3 locked preset
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, "R3 ignored");
        // R8 mode change ignored while enabled
        wr(2'd0, 32'h1);
        rd(2'd0, "R8 mode kept");
        // R7 done strobe
        wr(2'd0, 32'h7);
        rd(2'd3, "R7 done clears");
        addr = 2'd2; #1;
        check("R9 mirrored", rd_data, ~ref_rev(32'h340B_C6D9));
        // R6 data while disabled
        wr(2'd0, 32'h2);
        wr(2'd1, 32'hA5);
        rd(2'd2, "R6 no effect");

        // R4 CRC-16 with preset upper ones, R10 upper zero
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, "R10 upper zero");
        wr(2'd0, 32'h1);
        wr(2'd1, 32'h31);
        wr(2'd1, 32'h32);
        rd(2'd2, "R4 crc16");
        wr(2'd0, 32'h0);
        rd(2'd3, "R7 disable clears");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0]  a = 2'($urandom % 4);
            logic [31:0] d = $urandom;
            if (a == 2'd0) d = {29'h0, d[2:0]};
            if (a == 2'd0 && ($urandom % 4) != 0) d[0] = 1'b1;
            if (a == 2'd0 && ($urandom % 3) == 0) d[2] = 1'b0;
            wr(a, d);
            rd(2'd2, "R2 R4 R5 R9 R10 random sum");
            rd(2'd3, "R7 random busy");
            rd(2'd0, "R8 random ctrl");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule